// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the command side of a small serial EEPROM. A host drives a serial clock, a data line and an active-low chip select. The block takes in instruction frames on the serial clock's rising edges. It decodes read, single-word write, write-to-every-word, write-enable and write-disable commands, and it keeps a write-enable latch that starts out cleared. Read data and status come back on a data output that has a separate drive-enable, updated on the serial clock's falling edges. A ready/busy output goes low while a timed programming cycle runs on the internal word array.

An active-high abort input acts only on write-type commands. If it is high at any point while a write-type frame is being shifted in, the frame is thrown away. If it goes high while a programming cycle is running, the cycle stops at once and nothing is committed. Reads and the two latch commands are not affected by it. The serial inputs are sampled by the system clock, so the serial clock must be slower than that clock.

Frame layout, MSB first: a start bit of 1, a 3-bit opcode, then ADDR_W address bits. Write-type frames then carry DATA_W data bits. The opcodes are 100 read, 101 write, 110 write-all, 011 write-enable and 010 write-disable. For write-all and the two latch commands the address bits are ignored. Other opcodes are ignored.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After rst_n is released, rdy is 1, do_en is 0, every word reads 0 and the write-enable latch is clear.
- R2: Bits are taken on SK rising edges only while cs_n is 0. Zero bits before the start bit (a 1) are skipped, and the opcode and address follow the start bit MSB first.
- R3: A read frame (1,100,addr) makes do_en 1 and puts the DATA_W bits of word addr on do_val, MSB first, one per SK falling edge after the last address bit. This happens whatever the latch state and the wr_abort level.
- R4: The write-enable frame (1,011,x) sets the latch and the write-disable frame (1,010,x; 10100000 with the default width) clears it. Both act the same way when wr_abort is high.
- R5: With the latch set, a write frame (1,101,addr,data) drives rdy to 0 for PROG_CYC clock cycles, after which word addr holds data. The array does not change at any other time.
- R6: With the latch set, a write-all frame (1,110,x,data) runs the same cycle and then loads data into every word.
- R7: With the latch clear, write and write-all frames leave rdy at 1 and the array unchanged.
- R8: If wr_abort is high at any clock from the start bit to the last data bit of a write-type frame, the frame is discarded: rdy stays 1, do_en stays 0 and the array is unchanged.
- R9: If wr_abort is high during a programming cycle, rdy returns to 1 on the next clock and nothing is committed. If cs_n is 0, do_en is 1 and do_val is 1.
- R10: While cs_n stays 0 after a write frame has started a cycle, do_en is 1 and do_val shows rdy (0 busy, 1 ready). This lasts until cs_n goes high, at which point do_en falls to 0.
- R11: Taking cs_n high in the middle of a frame discards the partial frame, and the next frame starts again from its start bit.
- R12: SK edges that arrive during a programming cycle are ignored, so a command sent then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| wr_abort | input | 1 | Active-high abort for write-type operations |
| do_val | output | 1 | Serial data or status out |
| do_en | output | 1 | Drive enable for do_val (0 means high impedance) |
| rdy | output | 1 | Ready (1) or busy (0) |

## Verification
Four properties are checked on every cycle. A programming cycle may only start while the latch is set. An abort during a cycle ends it on the next clock with the array unchanged. The array stays fixed whenever no cycle is running. The latch moves only on a serial clock rising edge. The bench scenarios are needed for the rest: frame decoding with leading zeros, the order and timing of read bits, the length of the busy window, discarding a frame when the abort arrives during shift-in or when chip select is raised mid-frame, status on the data output, and commands sent during a cycle having no effect. All of these show up only in port values across whole frames.

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  input  logic di,
  input  logic cs_n,
  input  logic wr_abort,
  output logic do_val,
  output logic do_en,
  output logic rdy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int INS_W = 4 + ADDR_W;
  localparam int FRM_W = INS_W + DATA_W;
  localparam int SH_W  = (DATA_W > INS_W - 1) ? DATA_W : INS_W - 1;
  localparam int CNT_W = $clog2(FRM_W + 1);
  localparam int PG_W  = $clog2(PROG_CYC + 1);
  localparam int RD_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] INS_C = CNT_W'(INS_W);
  localparam logic [CNT_W-1:0] FRM_C = CNT_W'(FRM_W);
  localparam logic [2:0] OP_EWDS  = 3'b010;
  localparam logic [2:0] OP_EWEN  = 3'b011;
  localparam logic [2:0] OP_READ  = 3'b100;
  localparam logic [2:0] OP_WRITE = 3'b101;
  localparam logic [2:0] OP_WRALL = 3'b110;

  logic sk_q, started, spoil, wel, busy, pg_all, rd_drv, do_q, stat_en;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-2:0] sh;
  logic [2:0] op_q;
  logic [ADDR_W-1:0] adr_q, pg_adr;
  logic [PG_W-1:0] pg_cnt;
  logic [DATA_W-1:0] pg_dat, rd_sh;
  logic [RD_W-1:0] rd_left;
  logic [DEPTH-1:0][DATA_W-1:0] mem;

  wire sk_rise = sk & ~sk_q & ~cs_n;
  wire sk_fall = ~sk & sk_q & ~cs_n;
  wire take = sk_rise & ~busy;
  wire [SH_W-1:0] sh_n = {sh, di};
  wire [CNT_W-1:0] cnt_n = cnt + 1'b1;
  wire [2:0] op_n = sh_n[INS_W-2 -: 3];
  wire ins_done = take & started & (cnt_n == INS_C);
  wire frm_done = take & started & (cnt_n == FRM_C);
  wire wr_ok = frm_done & wel & ~spoil & ~wr_abort;

  assign rdy    = ~busy;
  assign do_en  = ~cs_n & (rd_drv | stat_en);
  assign do_val = rd_drv ? do_q : ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      spoil   <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      op_q    <= '0;
      adr_q   <= '0;
    end else if (cs_n) begin
      started <= 1'b0;
      spoil   <= 1'b0;
      cnt     <= '0;
    end else begin
      if (started && wr_abort) spoil <= 1'b1;
      if (take) begin
        if (!started) begin
          if (di) begin
            started <= 1'b1;
            cnt     <= CNT_W'(1);
            sh      <= sh_n[SH_W-2:0];
            spoil   <= wr_abort;
          end
        end else begin
          sh  <= sh_n[SH_W-2:0];
          cnt <= cnt_n;
          if (cnt_n == INS_C) begin
            op_q  <= op_n;
            adr_q <= sh_n[ADDR_W-1:0];
            if (op_n != OP_WRITE && op_n != OP_WRALL) begin
              started <= 1'b0;
              spoil   <= 1'b0;
            end
          end
          if (cnt_n == FRM_C) begin
            started <= 1'b0;
            spoil   <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else if (ins_done && op_n == OP_EWEN) wel <= 1'b1;
    else if (ins_done && op_n == OP_EWDS) wel <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pg_cnt <= '0;
      pg_adr <= '0;
      pg_dat <= '0;
      pg_all <= 1'b0;
      mem    <= '0;
    end else if (busy) begin
      if (wr_abort) busy <= 1'b0;
      else if (pg_cnt == PG_W'(1)) begin
        busy <= 1'b0;
        if (pg_all) mem <= {DEPTH{pg_dat}};
        else        mem[pg_adr] <= pg_dat;
      end else pg_cnt <= pg_cnt - 1'b1;
    end else if (wr_ok) begin
      busy   <= 1'b1;
      pg_cnt <= PG_W'(PROG_CYC);
      pg_adr <= adr_q;
      pg_dat <= sh_n[DATA_W-1:0];
      pg_all <= (op_q == OP_WRALL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh   <= '0;
      rd_left <= '0;
      rd_drv  <= 1'b0;
      do_q    <= 1'b0;
      stat_en <= 1'b0;
    end else if (cs_n) begin
      rd_left <= '0;
      rd_drv  <= 1'b0;
      stat_en <= 1'b0;
    end else begin
      if (ins_done && op_n == OP_READ) begin
        rd_sh   <= mem[sh_n[ADDR_W-1:0]];
        rd_left <= RD_W'(DATA_W);
      end else if (sk_fall) begin
        if (rd_left != '0) begin
          do_q    <= rd_sh[DATA_W-1];
          rd_sh   <= rd_sh << 1;
          rd_left <= rd_left - 1'b1;
          rd_drv  <= 1'b1;
        end else rd_drv <= 1'b0;
      end
      if (wr_ok || (busy && wr_abort)) stat_en <= 1'b1;
      else if (take && !started && di) stat_en <= 1'b0;
    end
  end

  // R7
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_abort |=> !busy && $stable(mem));

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mem));

  // R4
  wel_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wel) |-> $past(sk_rise));
endmodule

// File: tb/eeprom_cmd_ctrl_bench.sv
module eeprom_cmd_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int PC = 200;

  logic clk = 1'b0, rst_n = 1'b0, sk = 1'b0, di = 1'b0, cs_n = 1'b1, wr_abort = 1'b0;
  logic do_val, do_en, rdy;
  int checks = 0, errors = 0;
  logic [DW-1:0] model [1<<AW];
  logic [DW-1:0] exp_q[$], act_q[$];
  string tag_q[$];

  eeprom_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(PC)) u_eeprom_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .sk(sk), .di(di), .cs_n(cs_n), .wr_abort(wr_abort),
    .do_val(do_val), .do_en(do_en), .rdy(rdy));

  always #2 clk = ~clk;

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    di = b; sk = 1'b0; ticks(4);
    sk = 1'b1; ticks(4);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic open_frame();
    sk = 1'b0; cs_n = 1'b0; ticks(2);
  endtask

  task automatic close_frame();
    sk = 1'b0; ticks(2); cs_n = 1'b1; ticks(4);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit lead, input string tag);
    logic [DW-1:0] w;
    logic en_all;
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
    open_frame();
    if (lead) begin bit_out(1'b0); bit_out(1'b0); end
    send({8'h0, 4'b1100, a}, 8);
    en_all = 1'b1;
    for (int i = DW - 1; i >= 0; i--) begin
      sk = 1'b0; ticks(4);
      w[i] = do_val;
      en_all = en_all & do_en;
      sk = 1'b1; ticks(4);
    end
    check({tag, " read do_en"}, en_all, 1);
    act_q.push_back(w);
    close_frame();
  endtask

  task automatic cmd(input logic [2:0] op);
    open_frame(); send({8'h0, 1'b1, op, 4'b0000}, 8); close_frame();
  endtask

  task automatic wframe(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    send({8'h0, 1'b1, op, a}, 8);
    send({8'h0, d}, DW);
  endtask

  initial begin : monitor
    logic [DW-1:0] e, a;
    string t;
    forever begin
      wait (act_q.size() > 0);
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      check({t, " read data"}, a, e);
    end
  end

  initial begin : watchdog
    ticks(150000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    ticks(5); rst_n = 1'b1; ticks(3);
    check("R1 rdy", rdy, 1);
    check("R1 do_en", do_en, 0);
    do_read(4'd9, 1'b0, "R1");

    open_frame(); wframe(3'b101, 4'd3, 8'hA5);
    check("R7 rdy", rdy, 1);
    close_frame();
    do_read(4'd3, 1'b0, "R7");

    cmd(3'b011);
    open_frame(); wframe(3'b101, 4'd3, 8'h5A);
    check("R5 busy", rdy, 0);
    check("R10 do_en busy", do_en, 1);
    check("R10 do_val busy", do_val, 0);
    ticks(PC / 2);
    check("R5 still busy", rdy, 0);
    ticks(PC);
    check("R5 ready", rdy, 1);
    check("R10 do_val ready", do_val, 1);
    close_frame();
    check("R10 do_en after cs", do_en, 0);
    model[3] = 8'h5A;
    do_read(4'd3, 1'b1, "R2");
    do_read(4'd3, 1'b0, "R5");

    open_frame(); wframe(3'b110, 4'd0, 8'h3C); close_frame();
    ticks(PC + 5);
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'h3C;
    do_read(4'd0, 1'b0, "R6");
    do_read(4'd15, 1'b0, "R6");

    open_frame();
    send({8'h0, 4'b1101, 4'd5}, 8);
    wr_abort = 1'b1; ticks(3); wr_abort = 1'b0;
    send({8'h0, 8'hE1}, DW);
    check("R8 rdy", rdy, 1);
    check("R8 do_en", do_en, 0);
    close_frame();
    do_read(4'd5, 1'b0, "R8");

    open_frame(); wframe(3'b101, 4'd6, 8'h77);
    ticks(5);
    wr_abort = 1'b1; ticks(3);
    check("R9 rdy", rdy, 1);
    check("R9 do_en", do_en, 1);
    check("R9 do_val", do_val, 1);
    wr_abort = 1'b0;
    close_frame();
    ticks(PC + 5);
    do_read(4'd6, 1'b0, "R9");

    open_frame(); send(16'h0014, 5); close_frame();
    do_read(4'd1, 1'b0, "R11");

    open_frame(); wframe(3'b101, 4'd2, 8'h11); close_frame();
    cmd(3'b010);
    ticks(PC);
    model[2] = 8'h11;
    open_frame(); wframe(3'b101, 4'd4, 8'h22); close_frame();
    ticks(PC + 5);
    model[4] = 8'h22;
    do_read(4'd4, 1'b0, "R12");
    do_read(4'd2, 1'b0, "R5");

    wr_abort = 1'b1; cmd(3'b010); wr_abort = 1'b0;
    open_frame(); wframe(3'b101, 4'd7, 8'h99);
    check("R4 disabled rdy", rdy, 1);
    close_frame();
    do_read(4'd7, 1'b0, "R4");

    wr_abort = 1'b1;
    do_read(4'd4, 1'b0, "R3");
    wr_abort = 1'b0;

    ticks(4);
    wait (act_q.size() == 0);
    ticks(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule